// File: doc/BRIEF.md
# In-Order Precise Exception Arbiter

This block follows every instruction through a five-slot pipeline (fetch, decode, execute, memory, writeback). It collects the faults that each stage reports about that instruction. It does not act on a fault when the fault appears. Each instruction carries a cause vector along with its PC from slot to slot. The vector is examined only in the writeback slot, which is the single point where state is committed. An instruction with a clean vector commits. An instruction whose vector holds any bit is taken as an exception instead. When that happens, its own state update is withheld and every younger instruction still in flight becomes a bubble in the same cycle. The faulting PC and a cause code are latched, and on the next cycle fetch is steered to a fixed handler address.

Because a fault is acted on only when its instruction is the oldest one left, exceptions are taken in program order. This holds even when a younger instruction faults in fetch before an older load faults in the memory stage. An external interrupt request is latched as pending. It is attached to the instruction in the memory slot as a lowest-priority cause, so that instruction is taken cleanly before any of its state changes.

Instructions enter through a valid/ready stream. A word is accepted on a clock edge where `in_valid_i` and `in_ready_o` are both high. The upstream fetch logic must hold its word while `in_ready_o` is low. `in_ready_o` drops for exactly two cycles: the cycle in which an exception is taken and the redirect cycle that follows it. All other pins are plain control and status signals.

Top module: `exc_order_arbiter`

## Requirements
- R1: A word accepted at an edge reaches the writeback slot five cycles later, where `commit_o` (when clean) shows it with its PC on `commit_pc_o`. `in_ready_o` is low in the take cycle and the redirect cycle, and high otherwise.
- R2: Cause codes are fixed. Fetch page fault=1, fetch misaligned=2, fetch protection=3, undefined opcode in decode=4, arithmetic fault in execute=5, memory page fault=6, memory misaligned=7, memory protection=8, interrupt=9, none=0. On `if_fault_i` and `mem_fault_i`, bit 0 is the page fault, bit 1 the misalignment and bit 2 the protection violation. Each fault input applies to the instruction that occupies that stage in the same cycle.
- R3: A writeback instruction with any recorded cause never raises `commit_o`. It raises `take_o` instead.
- R4: `mem_wr_en_o` is high only for a valid memory-slot instruction that requests a store (`mem_store_i`) and has no cause, counting a memory fault raised in that same cycle. It is low in a take cycle.
- R5: The reported code comes from the instruction's own vector and is the lowest code present. An older instruction's memory fault is taken before a younger instruction's fetch fault, even when the younger fault was flagged first. Once an instruction has a cause, later stages add no more causes to it.
- R6: In a take cycle, every younger instruction in fetch, decode, execute and memory becomes a bubble. None of them ever commits, is taken, or writes memory.
- R7: On a take, `epc_o` becomes the faulting instruction's PC and `ecause_o` its code, both visible on the next cycle. Both hold until the next take.
- R8: `redir_o` pulses for one cycle, the cycle after a take, with `redir_pc_o` equal to the `HANDLER_PC` parameter.
- R9: `irq_i` sets a pending flag. While the flag is set, a clean instruction in the memory slot gains code 9 (its store is suppressed). The flag clears only when an interrupt-coded take occurs.
- R10: After reset every slot is empty. `commit_o`, `take_o`, `redir_o` and `mem_wr_en_o` are low, `in_ready_o` is high, and `epc_o` and `ecause_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid_i | input | 1 | Fetch word valid |
| in_ready_o | output | 1 | Arbiter can accept a fetch word |
| in_pc_i | input | PC_W | PC of the fetch word |
| if_fault_i | input | 3 | Fetch-stage faults for the fetch-slot instruction |
| id_fault_i | input | 1 | Undefined opcode for the decode-slot instruction |
| ex_fault_i | input | 1 | Arithmetic fault for the execute-slot instruction |
| mem_fault_i | input | 3 | Memory-stage faults for the memory-slot instruction |
| mem_store_i | input | 1 | Memory-slot instruction requests a store |
| irq_i | input | 1 | External interrupt request |
| mem_wr_en_o | output | 1 | Store may proceed this cycle |
| commit_o | output | 1 | Writeback instruction updates state |
| commit_pc_o | output | PC_W | PC of the writeback instruction |
| take_o | output | 1 | Exception taken this cycle |
| epc_o | output | PC_W | Saved faulting PC |
| ecause_o | output | 4 | Saved cause code |
| redir_o | output | 1 | Redirect fetch this cycle |
| redir_pc_o | output | PC_W | Handler address |

## Verification
The bench sweeps all eight stage-fault causes over each of four instruction positions. This separates the code mapping from the way older instructions commit while younger ones are flushed. Every memory-fault/fetch-fault pairing between an older and a younger neighbour is applied. These pairs tell an arbiter that follows program order apart from one that acts on whichever fault arrives first in time. Single instructions carrying several causes show whether the lowest code wins. Interrupts are raised at four arrival times, followed by a clean stream. Together these show where the interrupt attaches, that the store of the taken instruction is withheld, and that the pending flag is cleared afterwards.

// File: rtl/exc_order_pkg.sv
package exc_order_pkg;
  localparam int NSTAGE  = 5;
  localparam int NCAUSE  = 9;
  localparam int CAUSE_W = 4;

  // bit positions in the cause vector; lower position = higher priority
  localparam int B_IF_PGF   = 0;
  localparam int B_IF_MIS   = 1;
  localparam int B_IF_PROT  = 2;
  localparam int B_ID_UND   = 3;
  localparam int B_EX_ARITH = 4;
  localparam int B_MEM_PGF  = 5;
  localparam int B_MEM_MIS  = 6;
  localparam int B_MEM_PROT = 7;
  localparam int B_IRQ      = 8;

  localparam logic [CAUSE_W-1:0] CODE_IRQ = CAUSE_W'(B_IRQ + 1);
endpackage

// File: rtl/exc_stage_reg.sv
module exc_stage_reg #(
  parameter int PC_W = 16,
  parameter int NC   = 9
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            d_valid,
  input  logic [PC_W-1:0] d_pc,
  input  logic [NC-1:0]   d_vec,
  output logic            q_valid,
  output logic [PC_W-1:0] q_pc,
  output logic [NC-1:0]   q_vec
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_valid <= 1'b0;
      q_pc    <= '0;
      q_vec   <= '0;
    end else begin
      q_valid <= d_valid;
      q_pc    <= d_pc;
      q_vec   <= d_vec;
    end
  end
endmodule

// File: rtl/exc_fault_merge.sv
module exc_fault_merge #(
  parameter int NC = 9
) (
  input  logic          valid_i,
  input  logic [NC-1:0] vec_i,
  input  logic [NC-1:0] raise_i,
  output logic [NC-1:0] vec_o
);
  // a cause is only recorded on a live instruction that is still clean
  always_comb begin
    if (valid_i && (vec_i == '0)) vec_o = raise_i;
    else                          vec_o = vec_i;
  end
endmodule

// File: rtl/exc_prio_enc.sv
module exc_prio_enc #(
  parameter int NC = 9,
  parameter int CW = 4
) (
  input  logic [NC-1:0] vec_i,
  output logic          any_o,
  output logic [CW-1:0] code_o
);
  always_comb begin
    code_o = '0;
    for (int i = NC - 1; i >= 0; i--) begin
      if (vec_i[i]) code_o = CW'(i + 1);
    end
  end
  assign any_o = |vec_i;
endmodule

// File: rtl/exc_order_arbiter.sv
module exc_order_arbiter
  import exc_order_pkg::*;
#(
  parameter int              PC_W       = 16,
  parameter logic [PC_W-1:0] HANDLER_PC = 'h0100
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid_i,
  output logic               in_ready_o,
  input  logic [PC_W-1:0]    in_pc_i,
  input  logic [2:0]         if_fault_i,
  input  logic               id_fault_i,
  input  logic               ex_fault_i,
  input  logic [2:0]         mem_fault_i,
  input  logic               mem_store_i,
  input  logic               irq_i,
  output logic               mem_wr_en_o,
  output logic               commit_o,
  output logic [PC_W-1:0]    commit_pc_o,
  output logic               take_o,
  output logic [PC_W-1:0]    epc_o,
  output logic [CAUSE_W-1:0] ecause_o,
  output logic               redir_o,
  output logic [PC_W-1:0]    redir_pc_o
);
  localparam int WB  = NSTAGE - 1;
  localparam int MEM = NSTAGE - 2;

  logic [NSTAGE-1:0] s_valid;
  logic [PC_W-1:0]   s_pc    [NSTAGE];
  logic [NCAUSE-1:0] s_vec   [NSTAGE];
  logic [NCAUSE-1:0] raise   [NSTAGE-1];
  logic [NCAUSE-1:0] aug_vec [NSTAGE-1];

  logic               take;
  logic               wb_any;
  logic [CAUSE_W-1:0] wb_code;
  logic               irq_pend_q;
  logic               redir_q;
  logic [PC_W-1:0]    epc_q;
  logic [CAUSE_W-1:0] ecause_q;

  // stream side: blocked during the take cycle and the redirect cycle
  assign in_ready_o = ~(take | redir_q);

  // per-stage raise masks, laid into the shared cause vector
  always_comb begin
    for (int i = 0; i < NSTAGE - 1; i++) raise[i] = '0;
    raise[0][B_IF_PGF]     = if_fault_i[0];
    raise[0][B_IF_MIS]     = if_fault_i[1];
    raise[0][B_IF_PROT]    = if_fault_i[2];
    raise[1][B_ID_UND]     = id_fault_i;
    raise[2][B_EX_ARITH]   = ex_fault_i;
    raise[MEM][B_MEM_PGF]  = mem_fault_i[0];
    raise[MEM][B_MEM_MIS]  = mem_fault_i[1];
    raise[MEM][B_MEM_PROT] = mem_fault_i[2];
    raise[MEM][B_IRQ]      = irq_pend_q;
  end

  for (genvar g = 0; g < NSTAGE; g++) begin : g_stage
    logic              dv;
    logic [PC_W-1:0]   dpc;
    logic [NCAUSE-1:0] dvec;

    if (g == 0) begin : g_head
      assign dv   = in_valid_i & in_ready_o;
      assign dpc  = in_pc_i;
      assign dvec = '0;
    end else begin : g_body
      // a take turns every younger instruction into a bubble
      assign dv   = s_valid[g-1] & ~take;
      assign dpc  = s_pc[g-1];
      assign dvec = aug_vec[g-1];
    end

    exc_stage_reg #(.PC_W(PC_W), .NC(NCAUSE)) u_reg (
      .clk     (clk),
      .rst_n   (rst_n),
      .d_valid (dv),
      .d_pc    (dpc),
      .d_vec   (dvec),
      .q_valid (s_valid[g]),
      .q_pc    (s_pc[g]),
      .q_vec   (s_vec[g])
    );

    if (g < NSTAGE - 1) begin : g_merge
      exc_fault_merge #(.NC(NCAUSE)) u_merge (
        .valid_i (s_valid[g]),
        .vec_i   (s_vec[g]),
        .raise_i (raise[g]),
        .vec_o   (aug_vec[g])
      );
    end
  end

  exc_prio_enc #(.NC(NCAUSE), .CW(CAUSE_W)) u_enc (
    .vec_i  (s_vec[WB]),
    .any_o  (wb_any),
    .code_o (wb_code)
  );

  assign take        = s_valid[WB] & wb_any;
  assign take_o      = take;
  assign commit_o    = s_valid[WB] & ~wb_any;
  assign commit_pc_o = s_pc[WB];

  assign mem_wr_en_o = s_valid[MEM] & mem_store_i & ~(|aug_vec[MEM]) & ~take;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      epc_q      <= '0;
      ecause_q   <= '0;
      redir_q    <= 1'b0;
      irq_pend_q <= 1'b0;
    end else begin
      redir_q    <= take;
      irq_pend_q <= (irq_pend_q & ~(take && (wb_code == CODE_IRQ))) | irq_i;
      if (take) begin
        epc_q    <= s_pc[WB];
        ecause_q <= wb_code;
      end
    end
  end

  assign epc_o      = epc_q;
  assign ecause_o   = ecause_q;
  assign redir_o    = redir_q;
  assign redir_pc_o = HANDLER_PC;
endmodule

// File: rtl/exc_order_checks.sv
module exc_order_checks #(
  parameter int              PC_W       = 16,
  parameter logic [PC_W-1:0] HANDLER_PC = 'h0100
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_ready_o,
  input logic            take_o,
  input logic            commit_o,
  input logic [PC_W-1:0] commit_pc_o,
  input logic            mem_wr_en_o,
  input logic            mem_store_i,
  input logic            redir_o,
  input logic [PC_W-1:0] redir_pc_o,
  input logic [PC_W-1:0] epc_o,
  input logic [3:0]      ecause_o
);
  assert_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (take_o || redir_o) |-> !in_ready_o);

  assert_store_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_en_o |-> (mem_store_i && !take_o));

  assert_flush_R6: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |=> (!take_o && !commit_o && !mem_wr_en_o));

  assert_save_R7: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |=> (epc_o == $past(commit_pc_o) && ecause_o != 4'd0));

  assert_keep_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !take_o |=> ($stable(epc_o) && $stable(ecause_o)));

  assert_redirect_R8: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |=> (redir_o && redir_pc_o == HANDLER_PC));
endmodule

bind exc_order_arbiter exc_order_checks #(.PC_W(PC_W), .HANDLER_PC(HANDLER_PC)) u_checks (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_ready_o  (in_ready_o),
  .take_o      (take_o),
  .commit_o    (commit_o),
  .commit_pc_o (commit_pc_o),
  .mem_wr_en_o (mem_wr_en_o),
  .mem_store_i (mem_store_i),
  .redir_o     (redir_o),
  .redir_pc_o  (redir_pc_o),
  .epc_o       (epc_o),
  .ecause_o    (ecause_o)
);

// File: tb/test_exc_order_arbiter.sv
`timescale 1ns/1ps
module test_exc_order_arbiter;
  localparam int          PC_W = 16;
  localparam logic [15:0] HPC  = 16'h0100;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid_i = 1'b0;
  logic [15:0] in_pc_i = '0;
  logic [2:0] if_fault_i = '0;
  logic id_fault_i = 1'b0;
  logic ex_fault_i = 1'b0;
  logic [2:0] mem_fault_i = '0;
  logic mem_store_i = 1'b0;
  logic irq_i = 1'b0;
  logic in_ready_o, mem_wr_en_o, commit_o, take_o, redir_o;
  logic [15:0] commit_pc_o, epc_o, redir_pc_o;
  logic [3:0] ecause_o;

  exc_order_arbiter #(.PC_W(PC_W), .HANDLER_PC(HPC)) i_exc_order_arbiter (
    .clk(clk), .rst_n(rst_n), .in_valid_i(in_valid_i), .in_ready_o(in_ready_o),
    .in_pc_i(in_pc_i), .if_fault_i(if_fault_i), .id_fault_i(id_fault_i),
    .ex_fault_i(ex_fault_i), .mem_fault_i(mem_fault_i), .mem_store_i(mem_store_i),
    .irq_i(irq_i), .mem_wr_en_o(mem_wr_en_o), .commit_o(commit_o),
    .commit_pc_o(commit_pc_o), .take_o(take_o), .epc_o(epc_o), .ecause_o(ecause_o),
    .redir_o(redir_o), .redir_pc_o(redir_pc_o)
  );

  always #4 clk = ~clk;

  int vectors = 0;
  int fails = 0;
  int sc = 0;
  int irq_cyc = -1;
  logic [8:0] fm [4];
  logic st [4];
  logic [15:0] base;
  int last_cause = 0;

  task automatic chk(input string req, input string what, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int low_cause(input logic [8:0] v);
    for (int i = 0; i < 9; i++) if (v[i]) return i + 1;
    return 0;
  endfunction

  task automatic clear_prog();
    for (int k = 0; k < 4; k++) begin
      fm[k] = '0;
      st[k] = 1'b1;
    end
    irq_cyc = -1;
  endtask

  // four instructions fed back to back; instruction k sits in stage s in cycle k+1+s
  task automatic run(input string ctag);
    logic [8:0] eff [4];
    int k0;
    int cz;
    base = 16'h1000 + 16'(sc * 64);
    sc++;
    for (int k = 0; k < 4; k++) begin
      eff[k] = fm[k];
      if (irq_cyc >= 0 && k == irq_cyc - 3 && fm[k] == '0) eff[k] = 9'h100;
    end
    k0 = 4;
    for (int k = 3; k >= 0; k--) if (eff[k] != '0) k0 = k;
    cz = (k0 < 4) ? low_cause(eff[k0]) : 0;
    if (k0 < 4) last_cause = cz;
    for (int t = 0; t < 12; t++) begin
      @(posedge clk);
      #1;
      in_valid_i  = (t < 4);
      in_pc_i     = base + 16'(4 * t);
      if_fault_i  = '0;
      id_fault_i  = 1'b0;
      ex_fault_i  = 1'b0;
      mem_fault_i = '0;
      mem_store_i = 1'b0;
      irq_i       = (t == irq_cyc);
      for (int s = 0; s < 4; s++) begin
        int k;
        k = t - 1 - s;
        if (k >= 0 && k < 4) begin
          case (s)
            0: if_fault_i = fm[k][2:0];
            1: id_fault_i = fm[k][3];
            2: ex_fault_i = fm[k][4];
            default: begin
              mem_fault_i = fm[k][7:5];
              mem_store_i = st[k];
            end
          endcase
        end
      end
      #2;
      begin
        int kw, km;
        bit ec, et, ew, er, rd;
        kw = t - 5;
        km = t - 4;
        ec = (kw >= 0 && kw < 4 && kw < k0);
        et = (kw >= 0 && k0 < 4 && kw == k0);
        chk((kw > k0) ? "R6" : ctag, "commit_o", int'(commit_o), int'(ec));
        chk((kw > k0) ? "R6" : "R3", "take_o", int'(take_o), int'(et));
        if (ec) chk("R1", "commit_pc_o", int'(commit_pc_o), int'(base) + 4 * kw);
        ew = (km >= 0 && km < 4 && km < k0 && st[km]);
        chk("R4", "mem_wr_en_o", int'(mem_wr_en_o), int'(ew));
        er = !(k0 < 4 && (t == k0 + 5 || t == k0 + 6));
        chk("R1", "in_ready_o", int'(in_ready_o), int'(er));
        rd = (k0 < 4 && t == k0 + 6);
        chk("R8", "redir_o", int'(redir_o), int'(rd));
        if (rd) begin
          chk("R8", "redir_pc_o", int'(redir_pc_o), int'(HPC));
          chk("R7", "epc_o", int'(epc_o), int'(base) + 4 * k0);
          chk(ctag, "ecause_o", int'(ecause_o), cz);
        end
        if (t == 11) chk("R7", "ecause_o held", int'(ecause_o), last_cause);
      end
    end
    @(posedge clk);
    #1;
    in_valid_i = 1'b0;
    irq_i = 1'b0;
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #3;
    // R10: reset state
    chk("R10", "commit_o", int'(commit_o), 0);
    chk("R10", "take_o", int'(take_o), 0);
    chk("R10", "redir_o", int'(redir_o), 0);
    chk("R10", "mem_wr_en_o", int'(mem_wr_en_o), 0);
    chk("R10", "in_ready_o", int'(in_ready_o), 1);
    chk("R10", "epc_o", int'(epc_o), 0);
    chk("R10", "ecause_o", int'(ecause_o), 0);
    rst_n = 1'b1;

    // clean streams, all stores and alternate stores
    clear_prog();
    run("R3");
    clear_prog();
    st[1] = 1'b0;
    st[3] = 1'b0;
    run("R4");

    // every single cause on every position (R2)
    for (int b = 0; b < 8; b++) begin
      for (int k = 0; k < 4; k++) begin
        clear_prog();
        fm[k][b] = 1'b1;
        run("R2");
      end
    end

    // older memory fault against younger, earlier-flagged fetch fault (R5)
    for (int ko = 0; ko < 3; ko++) begin
      for (int bm = 5; bm < 8; bm++) begin
        for (int bi = 0; bi < 3; bi++) begin
          clear_prog();
          fm[ko][bm] = 1'b1;
          fm[ko+1][bi] = 1'b1;
          run("R5");
        end
      end
    end

    // several causes on one instruction: lowest code wins (R5)
    for (int bi = 0; bi < 5; bi++) begin
      clear_prog();
      fm[1][bi] = 1'b1;
      fm[1][7] = 1'b1;
      run("R5");
    end

    // interrupts arriving at each position, then a clean stream (R9)
    for (int k = 0; k < 4; k++) begin
      clear_prog();
      irq_cyc = k + 3;
      run("R9");
    end
    clear_prog();
    run("R9");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule